// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the device side of a legacy byte-wide configuration interface. It sees two bus locations: an index port and a data port, told apart by one address-select bit. A strap input picks which of two base ports the device lives at. The only visible effect of that choice is the last byte of the unlock key. Configuration space stays hidden until the host writes a four-byte key to the index port. After that the host addresses a register by writing its index to the index port, then reads or writes the register value through the data port. Writing 0x02 to register 0x02 locks the space again.

Inside configuration space there are three groups of registers. A read-only chip identifier reads as 0x8761. A logical-device select register chooses the device. When the GPIO logical device (0x02) is selected, the block also exposes a 16-bit runtime I/O base address and one 8-bit direction register for each group of eight pins. The base address and the direction bits leave the block as plain outputs, for the GPIO runtime window to use. That window is four bytes wide and is not part of this block.

The key matcher is a five-state machine: KEY_IDLE, KEY_ONE, KEY_TWO, KEY_THREE and CFG_OPEN. The transitions are:
- advance: a matching index-port byte moves one state forward.
- restart: a non-matching byte equal to 0x87 moves to KEY_ONE.
- drop: any other non-matching byte moves to KEY_IDLE.
- open: the correct fourth byte in KEY_THREE moves to CFG_OPEN.
- close: the exit write in CFG_OPEN moves back to KEY_IDLE.

Top module: `sio_cfg_port`

## Requirements
- R1: Index-port writes of 0x87, 0x61, 0x55 and then a fourth byte raise `cfg_active` on the clock edge that takes the fourth byte. The fourth byte is 0x55 when `strap_alt`=0 and 0xAA when `strap_alt`=1. The other value of the fourth byte leaves `cfg_active` low.
- R2: A key byte that does not match restarts the matcher. If that byte is 0x87 it counts as the first byte of a new key; any other byte sends the matcher back to idle.
- R3: While `cfg_active` is low, data-port writes change no register, and reads of either port return 0xFF.
- R4: While `cfg_active` is high, an index-port write selects the register that later data-port accesses reach, and an index-port read returns the selected index.
- R5: A data-port write of 0x02 while index 0x02 is selected clears `cfg_active` on that edge. Any other value written to index 0x02 has no effect.
- R6: Index 0x20 reads 0x87 and index 0x21 reads 0x61. Both are read-only.
- R7: Index 0x07 is the read/write logical-device select. The GPIO registers (0x60, 0x61, 0xF0, 0xF1) respond only while it holds 0x02. Otherwise they read 0x00 and ignore writes.
- R8: Index 0x60 holds `gpio_base[15:8]` and index 0x61 holds `gpio_base[7:0]`. Both are read/write.
- R9: Index 0xF0 holds the directions of pins 0-7 and index 0xF1 those of pins 8-15. The bit position is the pin number modulo 8, so `gpio_dir[n]` is pin n. A 1 makes the pin an output; both registers are read/write.
- R10: Unimplemented indices read 0x00, and writes to them have no effect.
- R11: Reset leaves configuration mode, selects logical device 0, sets the selected index to 0, and clears `gpio_base` and `gpio_dir`.
- R12: `rdata` is valid in the same cycle as `rd_stb`, with no wait cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Base-port strap: 0 selects the lower base, 1 the upper |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| addr_sel | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| cfg_active | output | 1 | Configuration space unlocked |
| gpio_base | output | 16 | GPIO runtime I/O base address |
| gpio_dir | output | 16 | Pin directions, 1 = output |

## Verification
The hardest condition to reach is a restart inside a key that is already partly matched. The matcher has to be in KEY_TWO when a stray 0x87 arrives, and then unlock from that byte rather than from idle. The bench sends 0x87, 0x61, 0x87, 0x61, 0x55, 0x55 and expects the block to unlock. It then sends keys that break off with a non-0x87 byte, and keys that end with the fourth byte meant for the other strap, and expects the block to stay locked. The logical-device gating is reached by writing the GPIO registers first with another device selected and then with device 0x02 selected, and comparing the outputs.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    typedef enum logic [2:0] {
        KEY_IDLE,
        KEY_ONE,
        KEY_TWO,
        KEY_THREE,
        CFG_OPEN
    } key_state_e;

    localparam logic [7:0] KEY_BYTE0    = 8'h87;
    localparam logic [7:0] KEY_BYTE1    = 8'h61;
    localparam logic [7:0] KEY_BYTE2    = 8'h55;
    localparam logic [7:0] KEY_LAST_LO  = 8'h55;
    localparam logic [7:0] KEY_LAST_HI  = 8'hAA;

    localparam logic [7:0] IDX_EXIT     = 8'h02;
    localparam logic [7:0] EXIT_CODE    = 8'h02;
    localparam logic [7:0] IDX_LDN      = 8'h07;
    localparam logic [7:0] IDX_ID_HI    = 8'h20;
    localparam logic [7:0] IDX_ID_LO    = 8'h21;
    localparam logic [7:0] IDX_BASE_HI  = 8'h60;
    localparam logic [7:0] IDX_BASE_LO  = 8'h61;
    localparam logic [7:0] IDX_DIR_BASE = 8'hF0;

    localparam logic [7:0] LOCKED_READ  = 8'hFF;

endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_alt,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic [7:0] wdata,
    input  logic [7:0] cur_idx,
    output logic       cfg_open
);

    key_state_e state_q, state_d;
    logic [7:0] last_key;
    logic       exit_hit;

    always_comb begin
        last_key = strap_alt ? KEY_LAST_HI : KEY_LAST_LO;
        exit_hit = data_wr && (cur_idx == IDX_EXIT) && (wdata == EXIT_CODE);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic: advance, restart, drop, open, close
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_IDLE: begin
                if (idx_wr && wdata == KEY_BYTE0) state_d = KEY_ONE;
            end
            KEY_ONE: begin
                if (idx_wr) begin
                    if (wdata == KEY_BYTE1)      state_d = KEY_TWO;
                    else if (wdata == KEY_BYTE0) state_d = KEY_ONE;
                    else                         state_d = KEY_IDLE;
                end
            end
            KEY_TWO: begin
                if (idx_wr) begin
                    if (wdata == KEY_BYTE2)      state_d = KEY_THREE;
                    else if (wdata == KEY_BYTE0) state_d = KEY_ONE;
                    else                         state_d = KEY_IDLE;
                end
            end
            KEY_THREE: begin
                if (idx_wr) begin
                    if (wdata == last_key)       state_d = CFG_OPEN;
                    else if (wdata == KEY_BYTE0) state_d = KEY_ONE;
                    else                         state_d = KEY_IDLE;
                end
            end
            CFG_OPEN: begin
                if (exit_hit) state_d = KEY_IDLE;
            end
            default: state_d = KEY_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cfg_open = (state_q == CFG_OPEN);
    end

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
#(
    parameter int          PINS     = 16,
    parameter logic [15:0] CHIP_ID  = 16'h8761,
    parameter logic [7:0]  LDN_GPIO = 8'h02
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_open,
    input  logic            idx_wr,
    input  logic            data_wr,
    input  logic [7:0]      wdata,
    output logic [7:0]      idx_q,
    output logic [7:0]      ldn_q,
    output logic [7:0]      cfg_rdata,
    output logic [15:0]     gpio_base,
    output logic [PINS-1:0] gpio_dir
);

    localparam int NBANK = PINS / 8;

    logic        reg_wr;
    logic        gpio_sel;
    logic [7:0]  base_hi_q, base_lo_q;
    logic [7:0]  dir_bank [NBANK];

    always_comb begin
        reg_wr   = cfg_open && data_wr;
        gpio_sel = (ldn_q == LDN_GPIO);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  idx_q <= 8'h00;
        else if (cfg_open && idx_wr) idx_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                            ldn_q <= 8'h00;
        else if (reg_wr && idx_q == IDX_LDN)   ldn_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi_q <= 8'h00;
            base_lo_q <= 8'h00;
        end else if (reg_wr && gpio_sel) begin
            if (idx_q == IDX_BASE_HI) base_hi_q <= wdata;
            if (idx_q == IDX_BASE_LO) base_lo_q <= wdata;
        end
    end

    assign gpio_base = {base_hi_q, base_lo_q};

    for (genvar k = 0; k < NBANK; k++) begin : g_dir
        localparam logic [7:0] BANK_IDX = IDX_DIR_BASE + 8'(k);
        always_ff @(posedge clk) begin
            if (!rst_n)
                dir_bank[k] <= 8'h00;
            else if (reg_wr && gpio_sel && idx_q == BANK_IDX)
                dir_bank[k] <= wdata;
        end
        assign gpio_dir[k*8 +: 8] = dir_bank[k];
    end

    // read mux
    always_comb begin
        cfg_rdata = 8'h00;
        if (idx_q == IDX_ID_HI)      cfg_rdata = CHIP_ID[15:8];
        else if (idx_q == IDX_ID_LO) cfg_rdata = CHIP_ID[7:0];
        else if (idx_q == IDX_LDN)   cfg_rdata = ldn_q;
        else if (gpio_sel) begin
            if (idx_q == IDX_BASE_HI)      cfg_rdata = base_hi_q;
            else if (idx_q == IDX_BASE_LO) cfg_rdata = base_lo_q;
            else begin
                for (int k = 0; k < NBANK; k++) begin
                    if (idx_q == IDX_DIR_BASE + 8'(k)) cfg_rdata = dir_bank[k];
                end
            end
        end
    end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int          PINS     = 16,
    parameter logic [15:0] CHIP_ID  = 16'h8761,
    parameter logic [7:0]  LDN_GPIO = 8'h02
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strap_alt,
    input  logic            wr_stb,
    input  logic            rd_stb,
    input  logic            addr_sel,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    output logic            cfg_active,
    output logic [15:0]     gpio_base,
    output logic [PINS-1:0] gpio_dir
);

    logic       idx_wr, data_wr;
    logic [7:0] idx_q, ldn_q, cfg_rdata;

    always_comb begin
        idx_wr  = wr_stb && !addr_sel;
        data_wr = wr_stb && addr_sel;
    end

    sio_key_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_alt(strap_alt),
        .idx_wr   (idx_wr),
        .data_wr  (data_wr),
        .wdata    (wdata),
        .cur_idx  (idx_q),
        .cfg_open (cfg_active)
    );

    sio_cfg_regs #(
        .PINS    (PINS),
        .CHIP_ID (CHIP_ID),
        .LDN_GPIO(LDN_GPIO)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_open (cfg_active),
        .idx_wr   (idx_wr),
        .data_wr  (data_wr),
        .wdata    (wdata),
        .idx_q    (idx_q),
        .ldn_q    (ldn_q),
        .cfg_rdata(cfg_rdata),
        .gpio_base(gpio_base),
        .gpio_dir (gpio_dir)
    );

    // read path; rd_stb is the host's timing qualifier only
    always_comb begin
        if (!cfg_active)   rdata = LOCKED_READ;
        else if (addr_sel) rdata = cfg_rdata;
        else               rdata = idx_q;
    end

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
    parameter int PINS = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            strap_alt,
    input logic            wr_stb,
    input logic            rd_stb,
    input logic            addr_sel,
    input logic [7:0]      wdata,
    input logic [7:0]      rdata,
    input logic            cfg_active,
    input logic [7:0]      idx_q,
    input logic [7:0]      ldn_q,
    input logic [15:0]     gpio_base,
    input logic [PINS-1:0] gpio_dir
);

    AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_active && rd_stb) |-> (rdata == 8'hFF)); // R3

    AST_LOCKED_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_active |=> $stable(gpio_dir)); // R3

    AST_ENTRY_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_active) |-> $past(wr_stb && !addr_sel &&
            wdata == (strap_alt ? 8'hAA : 8'h55))); // R1

    AST_EXIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_active && wr_stb && addr_sel && idx_q == 8'h02 && wdata == 8'h02)
        |=> !cfg_active); // R5

    AST_ID_HIGH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_active && rd_stb && addr_sel && idx_q == 8'h20) |-> (rdata == 8'h87)); // R6

    AST_BASE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (ldn_q != 8'h02) |=> $stable(gpio_base)); // R7

    AST_IDX_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_active && rd_stb && !addr_sel) |-> (rdata == idx_q)); // R4

endmodule

bind sio_cfg_port sio_cfg_port_chk #(.PINS(PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_alt (strap_alt),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .addr_sel  (addr_sel),
    .wdata     (wdata),
    .rdata     (rdata),
    .cfg_active(cfg_active),
    .idx_q     (idx_q),
    .ldn_q     (ldn_q),
    .gpio_base (gpio_base),
    .gpio_dir  (gpio_dir)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_alt = 1'b0;
    logic        wr_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic        addr_sel = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        cfg_active;
    logic [15:0] gpio_base;
    logic [15:0] gpio_dir;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    sio_cfg_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_alt (strap_alt),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .addr_sel  (addr_sel),
        .wdata     (wdata),
        .rdata     (rdata),
        .cfg_active(cfg_active),
        .gpio_base (gpio_base),
        .gpio_dir  (gpio_dir)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; addr_sel = sel; wdata = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    // R12: rdata sampled inside the strobe cycle
    task automatic bus_rd(input logic sel, output logic [7:0] d);
        @(negedge clk);
        rd_stb = 1'b1; addr_sel = sel;
        #2 d = rdata;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic key(input logic [7:0] b3);
        bus_wr(1'b0, 8'h87); bus_wr(1'b0, 8'h61);
        bus_wr(1'b0, 8'h55); bus_wr(1'b0, b3);
    endtask

    task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
        bus_wr(1'b0, i); bus_wr(1'b1, d);
    endtask

    task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
        bus_wr(1'b0, i); bus_rd(1'b1, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R11 cfg_active", cfg_active, 0);
        chk("R11 gpio_base", gpio_base, 0);
        chk("R11 gpio_dir", gpio_dir, 0);
        bus_rd(1'b1, d);
        chk("R3 locked data read", d, 8'hFF);
    endtask

    task automatic t_locked();
        logic [7:0] d;
        bus_wr(1'b1, 8'h5A);
        bus_rd(1'b0, d);
        chk("R3 locked index read", d, 8'hFF);
        chk("R3 locked write dir", gpio_dir, 0);
        chk("R3 locked write base", gpio_base, 0);
    endtask

    task automatic t_unlock_lo();
        bus_wr(1'b0, 8'h87); bus_wr(1'b0, 8'h61); bus_wr(1'b0, 8'h55);
        chk("R1 partial key", cfg_active, 0);
        bus_wr(1'b0, 8'h55);
        chk("R1 unlock strap0", cfg_active, 1);
    endtask

    task automatic t_id();
        logic [7:0] d;
        reg_rd(8'h20, d); chk("R6 id high", d, 8'h87);
        reg_rd(8'h21, d); chk("R6 id low", d, 8'h61);
        bus_rd(1'b0, d);  chk("R4 index readback", d, 8'h21);
        reg_wr(8'h20, 8'h00);
        reg_rd(8'h20, d); chk("R6 id read-only", d, 8'h87);
    endtask

    task automatic t_unimpl();
        logic [7:0] d;
        reg_wr(8'h33, 8'h5A);
        reg_rd(8'h33, d); chk("R10 unimplemented read", d, 8'h00);
    endtask

    task automatic t_ldn_gate();
        logic [7:0] d;
        reg_wr(8'h07, 8'h01);
        reg_rd(8'h07, d); chk("R7 ldn readback", d, 8'h01);
        reg_wr(8'h60, 8'h12);
        reg_wr(8'hF0, 8'hFF);
        chk("R7 base gated", gpio_base, 0);
        chk("R7 dir gated", gpio_dir, 0);
        reg_rd(8'h60, d); chk("R7 gated read", d, 8'h00);
    endtask

    task automatic t_gpio();
        logic [7:0] d;
        reg_wr(8'h07, 8'h02);
        reg_wr(8'h60, 8'h0A);
        reg_wr(8'h61, 8'h20);
        chk("R8 base", gpio_base, 16'h0A20);
        reg_rd(8'h60, d); chk("R8 base high read", d, 8'h0A);
        reg_wr(8'hF0, 8'h81);
        reg_wr(8'hF1, 8'h40);
        chk("R9 dir pins", gpio_dir, 16'h4081);
        reg_rd(8'hF1, d); chk("R9 dir high read", d, 8'h40);
    endtask

    task automatic t_exit();
        logic [7:0] d;
        reg_wr(8'h02, 8'h01);
        chk("R5 wrong exit value", cfg_active, 1);
        reg_wr(8'h02, 8'h02);
        chk("R5 exit", cfg_active, 0);
        bus_rd(1'b1, d); chk("R3 read after exit", d, 8'hFF);
        chk("R3 dir kept after exit", gpio_dir, 16'h4081);
    endtask

    task automatic t_mismatch();
        bus_wr(1'b0, 8'h87); bus_wr(1'b0, 8'h61); bus_wr(1'b0, 8'h00);
        bus_wr(1'b0, 8'h55); bus_wr(1'b0, 8'h55);
        chk("R2 broken key stays locked", cfg_active, 0);
        key(8'hAA);
        chk("R1 wrong last byte strap0", cfg_active, 0);
        bus_wr(1'b0, 8'h87); bus_wr(1'b0, 8'h61);
        bus_wr(1'b0, 8'h87); bus_wr(1'b0, 8'h61);
        bus_wr(1'b0, 8'h55); bus_wr(1'b0, 8'h55);
        chk("R2 restart on 0x87", cfg_active, 1);
        reg_wr(8'h02, 8'h02);
    endtask

    task automatic t_strap_alt();
        strap_alt = 1'b1;
        key(8'h55);
        chk("R1 strap1 rejects 0x55", cfg_active, 0);
        key(8'hAA);
        chk("R1 unlock strap1", cfg_active, 1);
    endtask

    task automatic t_reset_mid();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R11 reset closes", cfg_active, 0);
        chk("R11 reset base", gpio_base, 0);
        chk("R11 reset dir", gpio_dir, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked();
        t_unlock_lo();
        t_id();
        t_unimpl();
        t_ldn_gate();
        t_gpio();
        t_exit();
        t_mismatch();
        t_strap_alt();
        t_reset_mid();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule